// File: doc/BRIEF.md
# Iterative Multiply Divide Unit

This block is an unsigned arithmetic helper that works one step per strobe, not in one cycle. Software writes the operands into small latches. The write that supplies the last operand also starts the operation. After that, each pulse on an external step strobe moves the operation forward by one step. A multiply of two 8-bit values is a shift-and-add and needs 8 steps. A divide of a 16-bit dividend by an 8-bit divisor is a restoring division and needs 16 steps.

The two result registers can be read at any time, even while an operation is running. Between steps they hold the partial results. Software, or the surrounding timing logic, has to let enough strobes pass before it reads a final value. The strobes can come on every clock or be spaced out by any number of idle clocks. The unit only counts strobes. This lets a host keep the unit running through stretches where its own bus is stalled.

A start aborts whatever operation is in flight and begins the new one at once. A divide by zero needs no special handling. It runs the normal 16 steps and ends with a quotient of all ones and the dividend left unchanged as the remainder.

Top module: `itermd_unit`

## Requirements
- R1: After synchronous reset both result outputs read zero, and step strobes alone, with no start, leave them at zero.
- R2: Writing the multiplier to address 1 starts a multiply with the multiplicand latched at address 0. After k strobes (k ≤ 8) `prod_rem` equals multiplicand × (multiplier mod 2^k) and `quotient` equals multiplier >> k. From k = 8 on, the product is complete and further strobes change nothing.
- R3: Writing the divisor to address 4 starts a divide of the 16-bit dividend latched at addresses 2 (low byte) and 3 (high byte). After k strobes (k ≤ 16), with S = divisor·2^(16−k), `quotient` equals ⌊dividend / S⌋ and `prod_rem` equals dividend − quotient·S. From k = 16 on, the values are final.
- R4: A start command aborts any operation in progress, and the new operation begins from its initial state regardless of the previous operation's progress.
- R5: Writes to the operand latches (addresses 0, 2, 3) during an operation do not affect that operation. They only take effect at the next start.
- R6: A divide by a zero divisor ends after 16 strobes with `quotient` = 0xFFFF and `prod_rem` equal to the dividend. After k strobes the quotient is 2^k − 1.
- R7: Each strobe cycle advances the operation by exactly one step, whether strobes come back to back or with idle cycles between them. Without a strobe the results hold.
- R8: A strobe in the same cycle as a start command is not applied to the new operation.
- R9: Writes to addresses 5, 6 and 7 are ignored. They change no result and no latched operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe for the operand port |
| wr_addr | input | 3 | Write address (0 multiplicand, 1 multiplier+start, 2 dividend low, 3 dividend high, 4 divisor+start) |
| wr_data | input | OPW (8) | Write data |
| alu_edge | input | 1 | Step strobe, one arithmetic step per asserted cycle |
| prod_rem | output | 2·OPW (16) | Product during multiply, remainder during divide |
| quotient | output | 2·OPW (16) | Shifting multiplier during multiply, quotient during divide |

## Verification
The bench uses the default operand width OPW = 8. At this width the extreme cases can be driven directly: the largest multiplier 0xFF, the all-ones dividend 0xFFFF, divisor 255 and divisor 0. A reference model predicts both outputs on every clock from closed-form partial-result formulas. This covers the mid-operation values after any number of strobes, not just the final results. The stimulus includes aborts, operand writes while an operation runs, unused addresses, gaps between strobes, and a strobe that coincides with a start.

// File: rtl/imd_pkg.sv
package imd_pkg;

    // Operand port address map
    typedef enum logic [2:0] {
        ADR_MCAND   = 3'd0,
        ADR_MPLR_GO = 3'd1,
        ADR_DVD_LO  = 3'd2,
        ADR_DVD_HI  = 3'd3,
        ADR_DVSR_GO = 3'd4
    } wr_addr_e;

    // Per-cycle command from the sequencer to the datapath
    typedef struct packed {
        logic load_mul;
        logic load_div;
        logic do_mul;
        logic do_div;
    } step_cmd_t;

    function automatic logic addr_starts_op(input logic [2:0] a);
        return (a == ADR_MPLR_GO) || (a == ADR_DVSR_GO);
    endfunction

endpackage

// File: rtl/imd_operand_regs.sv
module imd_operand_regs
    import imd_pkg::*;
#(
    parameter int unsigned OPW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [2:0]       wr_addr,
    input  logic [OPW-1:0]   wr_data,
    output logic [OPW-1:0]   mcand,
    output logic [2*OPW-1:0] dividend,
    output logic             start_mul,
    output logic             start_div
);
    localparam int unsigned LANES = 2;

    assign start_mul = wr_valid && (wr_addr == ADR_MPLR_GO);
    assign start_div = wr_valid && (wr_addr == ADR_DVSR_GO);

    always_ff @(posedge clk) begin
        if (rst)
            mcand <= '0;
        else if (wr_valid && (wr_addr == ADR_MCAND))
            mcand <= wr_data;
    end

    // One byte lane of the dividend latch per address
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [2:0] LANE_ADR = 3'(ADR_DVD_LO) + 3'(l);
        logic [OPW-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (wr_valid && (wr_addr == LANE_ADR))
                lane_q <= wr_data;
        end

        assign dividend[l*OPW +: OPW] = lane_q;
    end

    // R9: addresses above the divisor never start an operation
    a_r9_no_start_high: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr > ADR_DVSR_GO) |-> !(start_mul || start_div));

    // R5: a start write does not touch the operand latches
    a_r5_latch_stable_on_start: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && addr_starts_op(wr_addr)) |=> ($stable(mcand) && $stable(dividend)));

endmodule

// File: rtl/imd_step_ctrl.sv
module imd_step_ctrl
    import imd_pkg::*;
#(
    parameter int unsigned OPW = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_mul,
    input  logic      start_div,
    input  logic      alu_edge,
    output step_cmd_t cmd
);
    localparam int unsigned MUL_STEPS = OPW;
    localparam int unsigned DIV_STEPS = 2 * OPW;
    localparam int unsigned CW        = $clog2(DIV_STEPS + 1);
    localparam logic [CW-1:0] MUL_N   = CW'(MUL_STEPS);
    localparam logic [CW-1:0] DIV_N   = CW'(DIV_STEPS);

    logic [CW-1:0] mul_cnt;
    logic [CW-1:0] div_cnt;
    logic          start_any;

    assign start_any = start_mul || start_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_cnt <= '0;
            div_cnt <= '0;
        end else if (start_any) begin
            mul_cnt <= start_mul ? MUL_N : '0;
            div_cnt <= start_div ? DIV_N : '0;
        end else if (alu_edge) begin
            if (mul_cnt != '0) mul_cnt <= mul_cnt - CW'(1);
            if (div_cnt != '0) div_cnt <= div_cnt - CW'(1);
        end
    end

    always_comb begin
        cmd          = '0;
        cmd.load_mul = start_mul;
        cmd.load_div = start_div;
        cmd.do_mul   = !start_any && alu_edge && (mul_cnt != '0);
        cmd.do_div   = !start_any && alu_edge && (div_cnt != '0);
    end

    // R4: a start reinitialises both counters
    a_r4_restart_mul: assert property (@(posedge clk) disable iff (rst)
        start_mul |=> (mul_cnt == MUL_N && div_cnt == '0));
    a_r4_restart_div: assert property (@(posedge clk) disable iff (rst)
        start_div |=> (div_cnt == DIV_N && mul_cnt == '0));
    // R4: never two operations in flight
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !((mul_cnt != '0) && (div_cnt != '0)));
    // R7: one step per strobe
    a_r7_one_step: assert property (@(posedge clk) disable iff (rst)
        (!start_any && alu_edge && mul_cnt != '0) |=> (mul_cnt == $past(mul_cnt) - CW'(1)));
    // R7: no strobe, no progress
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!start_any && !alu_edge) |=> ($stable(mul_cnt) && $stable(div_cnt)));
    // R8: a coinciding strobe is not spent on the new operation
    a_r8_start_masks_edge: assert property (@(posedge clk) disable iff (rst)
        (start_any && alu_edge) |=> (mul_cnt == MUL_N || div_cnt == DIV_N));

endmodule

// File: rtl/imd_datapath.sv
module imd_datapath
    import imd_pkg::*;
#(
    parameter int unsigned OPW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_cmd_t        cmd,
    input  logic [OPW-1:0]   mcand,
    input  logic [2*OPW-1:0] dividend,
    input  logic [OPW-1:0]   operand,
    output logic [2*OPW-1:0] acc_out,
    output logic [2*OPW-1:0] quo_out
);
    localparam int unsigned AW = 2 * OPW;
    localparam int unsigned SW = 3 * OPW;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [AW-1:0] quo;
        logic [SW-1:0] shf;
    } dp_state_t;

    dp_state_t     state_q;
    dp_state_t     state_d;
    logic [SW-1:0] shf_half;
    logic [AW-1:0] quo_shl;

    always_comb begin
        state_d  = state_q;
        shf_half = state_q.shf >> 1;
        quo_shl  = state_q.quo << 1;
        if (cmd.load_mul) begin
            state_d.acc = '0;
            state_d.quo = {{OPW{1'b0}}, operand};
            state_d.shf = {{AW{1'b0}}, mcand};
        end else if (cmd.load_div) begin
            state_d.acc = dividend;
            state_d.quo = '0;
            state_d.shf = {operand, {AW{1'b0}}};
        end else begin
            if (cmd.do_mul) begin
                if (state_q.quo[0])
                    state_d.acc = state_q.acc + state_q.shf[AW-1:0];
                state_d.quo = state_q.quo >> 1;
                state_d.shf = state_q.shf << 1;
            end
            if (cmd.do_div) begin
                if ({{OPW{1'b0}}, state_q.acc} >= shf_half) begin
                    state_d.acc = state_q.acc - shf_half[AW-1:0];
                    quo_shl[0]  = 1'b1;
                end
                state_d.quo = quo_shl;
                state_d.shf = shf_half;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign acc_out = state_q.acc;
    assign quo_out = state_q.quo;

    // R7: without a command the visible results hold
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !(cmd.load_mul || cmd.load_div || cmd.do_mul || cmd.do_div)
        |=> ($stable(acc_out) && $stable(quo_out)));
    // R3: after a divide step the remainder is below the current shifted divisor
    a_r3_rem_bound: assert property (@(posedge clk) disable iff (rst)
        cmd.do_div |=> ((state_q.shf == '0) || ({{OPW{1'b0}}, state_q.acc} < state_q.shf)));
    // R2: the multiplier register only drains during a multiply step
    a_r2_mplr_drains: assert property (@(posedge clk) disable iff (rst)
        cmd.do_mul |=> (quo_out <= $past(quo_out)));
    // R6: with a zero divisor the remainder never moves
    a_r6_zero_div_keeps_rem: assert property (@(posedge clk) disable iff (rst)
        (cmd.do_div && state_q.shf == '0) |=> $stable(acc_out));

endmodule

// File: rtl/itermd_unit.sv
module itermd_unit
    import imd_pkg::*;
#(
    parameter int unsigned OPW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [2:0]       wr_addr,
    input  logic [OPW-1:0]   wr_data,
    input  logic             alu_edge,
    output logic [2*OPW-1:0] prod_rem,
    output logic [2*OPW-1:0] quotient
);
    logic [OPW-1:0]   mcand;
    logic [2*OPW-1:0] dividend;
    logic             start_mul;
    logic             start_div;
    step_cmd_t        cmd;

    imd_operand_regs #(.OPW(OPW)) u_opnd (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mcand     (mcand),
        .dividend  (dividend),
        .start_mul (start_mul),
        .start_div (start_div)
    );

    imd_step_ctrl #(.OPW(OPW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_mul (start_mul),
        .start_div (start_div),
        .alu_edge  (alu_edge),
        .cmd       (cmd)
    );

    imd_datapath #(.OPW(OPW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .mcand    (mcand),
        .dividend (dividend),
        .operand  (wr_data),
        .acc_out  (prod_rem),
        .quo_out  (quotient)
    );

    // R1: out of reset the results are zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (prod_rem == '0 && quotient == '0));

endmodule

// File: tb/itermd_unit_tb_top.sv
`timescale 1ns/1ps
module itermd_unit_tb_top;
    localparam int OPW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        alu_edge = 1'b0;
    logic [15:0] prod_rem;
    logic [15:0] quotient;

    always #2 clk = ~clk;

    itermd_unit #(.OPW(OPW)) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .alu_edge(alu_edge),
        .prod_rem(prod_rem), .quotient(quotient)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Behavioural reference: mode, strobes taken, snapshots at start
    int    m_mode = 0;
    int    m_k = 0;
    bit    m_started;
    longint m_a = 0, m_b = 0, m_dvd = 0, m_dvs = 0;
    longint lat_a = 0, lat_dvd = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_k = 0; m_a = 0; m_b = 0; m_dvd = 0; m_dvs = 0;
            lat_a = 0; lat_dvd = 0;
        end else begin
            m_started = 1'b0;
            if (wr_valid) begin
                case (wr_addr)
                    3'd0: lat_a = longint'(wr_data);
                    3'd1: begin m_mode = 1; m_a = lat_a; m_b = longint'(wr_data); m_k = 0; m_started = 1'b1; end
                    3'd2: lat_dvd = (lat_dvd & 64'hFF00) | longint'(wr_data);
                    3'd3: lat_dvd = (lat_dvd & 64'h00FF) | (longint'(wr_data) << 8);
                    3'd4: begin m_mode = 2; m_dvd = lat_dvd; m_dvs = longint'(wr_data); m_k = 0; m_started = 1'b1; end
                    default: ;
                endcase
            end
            if (!m_started && alu_edge && m_mode != 0 && m_k < ((m_mode == 1) ? 8 : 16))
                m_k++;
        end
    end

    task automatic expected(output longint pr, output longint q);
        longint s;
        pr = 0; q = 0;
        if (m_mode == 1) begin
            pr = m_a * (m_b & ((64'd1 << m_k) - 1));
            q  = m_b >> m_k;
        end else if (m_mode == 2) begin
            if (m_dvs == 0) begin
                q  = (64'd1 << m_k) - 1;
                pr = m_dvd;
            end else begin
                s  = m_dvs << (16 - m_k);
                q  = m_dvd / s;
                pr = m_dvd - q * s;
            end
        end
    endtask

    always @(negedge clk) begin
        longint epr, eq;
        if (!rst && !done) begin
            expected(epr, eq);
            vectors++;
            if (prod_rem !== epr[15:0] || quotient !== eq[15:0]) begin
                miscompares++;
                $display("FAIL %s model: prod_rem=%0d quotient=%0d expected %0d %0d",
                         cur_tag, prod_rem, quotient, epr[15:0], eq[15:0]);
            end
        end
    end

    task automatic cyc(input bit v, input int a, input int d, input bit e);
        @(negedge clk);
        wr_valid = v; wr_addr = 3'(a); wr_data = 8'(d); alu_edge = e;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0);
    endtask

    // Spends one idle cycle and checks the outputs settled by the last drive
    task automatic peek(input string tag, input int epr, input int eq);
        cyc(1'b0, 0, 0, 1'b0);
        vectors++;
        if (prod_rem !== 16'(epr) || quotient !== 16'(eq)) begin
            miscompares++;
            $display("FAIL %s spot: prod_rem=%0d quotient=%0d expected %0d %0d",
                     tag, prod_rem, quotient, epr, eq);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, strobes without start
        cur_tag = "R1";
        peek("R1", 0, 0);
        edges(3);
        peek("R1", 0, 0);

        // R2: 200 x 255, partial after 3 strobes, final, then extra strobes
        cur_tag = "R2";
        cyc(1'b1, 0, 200, 1'b0);
        cyc(1'b1, 1, 255, 1'b0);
        edges(3);
        peek("R2", 1400, 31);
        edges(5);
        peek("R2", 51000, 0);
        edges(3);
        peek("R2", 51000, 0);

        // R7: gaps between strobes; 9 x 10
        cur_tag = "R7";
        cyc(1'b1, 0, 9, 1'b0);
        cyc(1'b1, 1, 10, 1'b0);
        edges(2);
        idle(5);
        peek("R7", 18, 2);
        edges(6);
        peek("R7", 90, 0);

        // R3: 50000 / 7 and 65535 / 255
        cur_tag = "R3";
        cyc(1'b1, 2, 8'h50, 1'b0);
        cyc(1'b1, 3, 8'hC3, 1'b0);
        cyc(1'b1, 4, 7, 1'b0);
        edges(16);
        peek("R3", 6, 7142);
        cyc(1'b1, 2, 8'hFF, 1'b0);
        cyc(1'b1, 3, 8'hFF, 1'b0);
        cyc(1'b1, 4, 255, 1'b0);
        edges(16);
        peek("R3", 0, 257);

        // R6: divide by zero
        cur_tag = "R6";
        cyc(1'b1, 2, 8'h34, 1'b0);
        cyc(1'b1, 3, 8'h12, 1'b0);
        cyc(1'b1, 4, 0, 1'b0);
        edges(4);
        peek("R6", 16'h1234, 16'h000F);
        edges(12);
        peek("R6", 16'h1234, 16'hFFFF);

        // R4: abort a multiply with a divide 1000 / 9
        cur_tag = "R4";
        cyc(1'b1, 0, 13, 1'b0);
        cyc(1'b1, 1, 11, 1'b0);
        edges(3);
        cyc(1'b1, 2, 8'hE8, 1'b0);
        cyc(1'b1, 3, 8'h03, 1'b0);
        cyc(1'b1, 4, 9, 1'b0);
        edges(16);
        peek("R4", 1, 111);

        // R5: operand writes mid-divide do not disturb it
        cur_tag = "R5";
        cyc(1'b1, 4, 9, 1'b0);
        edges(5);
        cyc(1'b1, 0, 77, 1'b1);
        cyc(1'b1, 2, 8'hFF, 1'b1);
        cyc(1'b1, 3, 8'hFF, 1'b1);
        edges(8);
        peek("R5", 1, 111);
        cyc(1'b1, 4, 1, 1'b0);
        edges(16);
        peek("R5", 0, 65535);

        // R8: start coinciding with a strobe; 3 x 255
        cur_tag = "R8";
        cyc(1'b1, 0, 3, 1'b0);
        cyc(1'b1, 1, 255, 1'b1);
        edges(7);
        peek("R8", 381, 1);
        edges(1);
        peek("R8", 765, 0);

        // R9: unused addresses ignored
        cur_tag = "R9";
        cyc(1'b1, 5, 8'h55, 1'b1);
        cyc(1'b1, 6, 8'h55, 1'b0);
        cyc(1'b1, 7, 8'h55, 1'b1);
        peek("R9", 765, 0);
        cyc(1'b1, 4, 5, 1'b0);
        edges(16);
        peek("R9", 0, 13107);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            summary();
            $finish;
        end
    end

endmodule